// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor three 8-bit parallel ports (A, B and C) and a control word register, all reached through a small register window. Two address bits pick the target: port A, port B, port C or the control register. Chip select, read strobe and write strobe come from the same clock domain as the block. The data bus has separate write and read paths, and each port has separate pin-in and pin-out vectors with a per-line drive enable. No tri-state exists inside the block.

The control word sets the direction of four port sections in basic mode: port A, port B, upper port C and lower port C. The 24 lines form two groups of twelve. One group is port A with port C bits 7:4, the other is port B with port C bits 3:0. A control-address write with bit 7 clear does not load a mode. It sets or clears one bit of the port C output register. Strobes and pin inputs pass through a multi-stage synchronizer. Write strobes are edge-detected, so a strobe held for many cycles performs one update.

Top module: `ppio_ctrl`

## Requirements
- R1: With `cs` high, a write strobe stores `wdata` at the selected address: 0 is port A, 1 is port B, 2 is port C. The stored port register appears on `pa_out`, `pb_out` or `pc_out`.
- R2: While `cs` is low, writes change no register and `rdata` stays 0.
- R3: After reset the control word is 0x9B, so every section is an input. All port output registers and all drive enables are 0.
- R4: A control-address write with bit 7 = 1 loads the mode word, where a 1 in a field means input. Bit 4 sets port A, bit 3 sets port C bits 7:4, bit 1 sets port B and bit 0 sets port C bits 3:0. The drive enable of every line in an output section is 1, and 0 otherwise.
- R5: Reading address 3 returns the stored control word bits 6:0, with bit 7 forced to 1.
- R6: A control-address write with bit 7 = 0 sets port C bit `wdata[3:1]` to `wdata[0]`. The other port C bits and the control word stay as they were.
- R7: Loading a mode word clears the port A, B and C output registers to 0.
- R8: Reading a port section set as input returns its synchronized pins. Reading a section set as output returns its output register. Port C applies this per nibble.
- R9: A write strobe held high for many cycles performs exactly one update, using the data present at its rising edge.
- R10: When no read is active, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data from processor |
| rdata | output | 8 | Read data to processor |
| pa_in | input | 8 | Port A pins in |
| pb_in | input | 8 | Port B pins in |
| pc_in | input | 8 | Port C pins in |
| pa_out | output | 8 | Port A output register |
| pb_out | output | 8 | Port B output register |
| pc_out | output | 8 | Port C output register |
| pa_drive | output | 8 | Port A per-line drive enable |
| pb_drive | output | 8 | Port B per-line drive enable |
| pc_drive | output | 8 | Port C per-line drive enable |

## Verification
The assertions assume that `addr` and `wdata` are stable from the time a strobe is raised until it has passed the synchronizer and been acted on. Only the strobes and pins are synchronized; the address and data are not. The stimulus holds the address and data steady for several cycles around every strobe and changes them only while the strobes are low. The one exception is the held-strobe case, where the data changes well after the edge has been consumed. Pin values are set many cycles before any read that depends on them, so the synchronizer latency never decides an expected value.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

    localparam int DW   = 8;
    localparam int IDXW = $clog2(DW);

    typedef enum logic [1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CTL = 2'd3
    } sel_e;

    // 1 = section is input
    typedef struct packed {
        logic a_in;
        logic chi_in;
        logic b_in;
        logic clo_in;
    } dir_t;

    typedef struct packed {
        logic wr_a;
        logic wr_b;
        logic wr_c;
        logic ld_mode;
        logic ld_bit;
    } act_t;

    localparam logic [6:0] CW_RESET = 7'h1B;

    function automatic dir_t dir_of(input logic [6:0] cw);
        dir_t d;
        d.a_in   = cw[4];
        d.chi_in = cw[3];
        d.b_in   = cw[1];
        d.clo_in = cw[0];
        return d;
    endfunction

    function automatic logic [DW-1:0] bit_cmd(input logic [DW-1:0] cur,
                                              input logic [IDXW-1:0] idx,
                                              input logic val);
        logic [DW-1:0] r;
        r      = cur;
        r[idx] = val;
        return r;
    endfunction

endpackage

// File: rtl/ppio_sync.sv
module ppio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ppio_ctl.sv
module ppio_ctl
    import ppio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  sel_e          sel,
    input  logic [DW-1:0] wdata,
    output logic [6:0]    cw,
    output act_t          act
);
    logic wr_d;
    logic wr_edge;

    always_ff @(posedge clk) begin
        if (rst) wr_d <= 1'b0;
        else     wr_d <= wr_stb;
    end

    assign wr_edge = wr_stb & ~wr_d;

    always_comb begin
        act = '0;
        if (wr_edge) begin
            unique case (sel)
                SEL_A:   act.wr_a = 1'b1;
                SEL_B:   act.wr_b = 1'b1;
                SEL_C:   act.wr_c = 1'b1;
                SEL_CTL: begin
                    if (wdata[DW-1]) act.ld_mode = 1'b1;
                    else             act.ld_bit  = 1'b1;
                end
                default: act = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              cw <= CW_RESET;
        else if (act.ld_mode) cw <= wdata[6:0];
    end

    // R9: a strobe that was already high last cycle triggers nothing
    assert_held_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_d) |-> (act == '0));

    // R6: bit commands leave the control word alone
    assert_cw_keep_R6: assert property (@(posedge clk) disable iff (rst)
        act.ld_bit |=> $stable(cw));

    // R2: without a strobe edge the control word holds
    assert_cw_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(cw));
endmodule

// File: rtl/ppio_ports.sv
module ppio_ports
    import ppio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  dir_t          dir,
    input  act_t          act,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pa_pin,
    input  logic [DW-1:0] pb_pin,
    input  logic [DW-1:0] pc_pin,
    output logic [DW-1:0] pa_q,
    output logic [DW-1:0] pb_q,
    output logic [DW-1:0] pc_q,
    output logic [DW-1:0] view_a,
    output logic [DW-1:0] view_b,
    output logic [DW-1:0] view_c
);
    localparam int HALF = DW / 2;

    always_ff @(posedge clk) begin
        if (rst || act.ld_mode) begin
            pa_q <= '0;
            pb_q <= '0;
            pc_q <= '0;
        end else begin
            if (act.wr_a) pa_q <= wdata;
            if (act.wr_b) pb_q <= wdata;
            if (act.wr_c)
                pc_q <= wdata;
            else if (act.ld_bit)
                pc_q <= bit_cmd(pc_q, wdata[IDXW:1], wdata[0]);
        end
    end

    assign view_a = dir.a_in ? pa_pin : pa_q;
    assign view_b = dir.b_in ? pb_pin : pb_q;

    // port C read view is chosen nibble by nibble
    for (genvar n = 0; n < 2; n++) begin : g_cnib
        logic nib_in;
        assign nib_in = (n == 0) ? dir.clo_in : dir.chi_in;
        assign view_c[n*HALF +: HALF] = nib_in ? pc_pin[n*HALF +: HALF]
                                               : pc_q[n*HALF +: HALF];
    end

    assert_mode_clear_R7: assert property (@(posedge clk) disable iff (rst)
        act.ld_mode |=> (pa_q == '0 && pb_q == '0 && pc_q == '0));

    assert_bit_only_R6: assert property (@(posedge clk) disable iff (rst)
        act.ld_bit |=> (((pc_q ^ $past(pc_q)) &
                        ~(8'b1 << $past(wdata[IDXW:1]))) == '0));

    assert_bit_value_R6: assert property (@(posedge clk) disable iff (rst)
        act.ld_bit |=> (pc_q[$past(wdata[IDXW:1])] == $past(wdata[0])));

    assert_a_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !(act.wr_a || act.ld_mode) |=> $stable(pa_q));
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
    import ppio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs,
    input  logic         rd,
    input  logic         wr,
    input  logic [1:0]   addr,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    input  logic [7:0]   pa_in,
    input  logic [7:0]   pb_in,
    input  logic [7:0]   pc_in,
    output logic [7:0]   pa_out,
    output logic [7:0]   pb_out,
    output logic [7:0]   pc_out,
    output logic [7:0]   pa_drive,
    output logic [7:0]   pb_drive,
    output logic [7:0]   pc_drive
);
    localparam int HALF = DW / 2;

    logic [2:0]      stb_s;
    logic [3*DW-1:0] pin_s;
    logic            cs_s, rd_s, wr_s;
    logic            rd_stb, wr_stb;
    logic [6:0]      cw;
    dir_t            dir;
    act_t            act;
    sel_e            sel;
    logic [DW-1:0]   view_a, view_b, view_c;

    ppio_sync #(.W(3), .STAGES(SYNC_STAGES)) u_stb_sync (
        .clk(clk), .rst(rst), .d({cs, rd, wr}), .q(stb_s)
    );

    ppio_sync #(.W(3*DW), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst(rst), .d({pa_in, pb_in, pc_in}), .q(pin_s)
    );

    assign {cs_s, rd_s, wr_s} = stb_s;
    assign rd_stb = cs_s & rd_s;
    assign wr_stb = cs_s & wr_s;
    assign sel    = sel_e'(addr);

    ppio_ctl u_ctl (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .sel(sel),
        .wdata(wdata), .cw(cw), .act(act)
    );

    assign dir = dir_of(cw);

    ppio_ports u_ports (
        .clk(clk), .rst(rst), .dir(dir), .act(act), .wdata(wdata),
        .pa_pin(pin_s[3*DW-1 -: DW]),
        .pb_pin(pin_s[2*DW-1 -: DW]),
        .pc_pin(pin_s[DW-1 -: DW]),
        .pa_q(pa_out), .pb_q(pb_out), .pc_q(pc_out),
        .view_a(view_a), .view_b(view_b), .view_c(view_c)
    );

    always_ff @(posedge clk) begin
        if (rst || !rd_stb) begin
            rdata <= '0;
        end else begin
            unique case (sel)
                SEL_A:   rdata <= view_a;
                SEL_B:   rdata <= view_b;
                SEL_C:   rdata <= view_c;
                SEL_CTL: rdata <= {1'b1, cw};
                default: rdata <= '0;
            endcase
        end
    end

    assign pa_drive = {DW{~dir.a_in}};
    assign pb_drive = {DW{~dir.b_in}};
    assign pc_drive = {{HALF{~dir.chi_in}}, {HALF{~dir.clo_in}}};

    assert_cw_msb_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && sel == SEL_CTL) |=> rdata[7]);

    assert_drive_load_R4: assert property (@(posedge clk) disable iff (rst)
        act.ld_mode |=> (pa_drive == {DW{~$past(wdata[4])}} &&
                         pb_drive == {DW{~$past(wdata[1])}}));

    assert_no_cs_R2: assert property (@(posedge clk) disable iff (rst)
        !cs_s |=> (rdata == '0));
endmodule

// File: tb/sim_ppio_ctrl.sv
`timescale 1ns/1ps
module sim_ppio_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 0, rd = 0, wr = 0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
    logic [7:0] pa_out, pb_out, pc_out, pa_drive, pb_drive, pc_drive;

    int checks = 0;
    int errors = 0;
    logic sample_now = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    ppio_ctrl u0 (
        .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pb_in(pb_in),
        .pc_in(pc_in), .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
        .pa_drive(pa_drive), .pb_drive(pb_drive), .pc_drive(pc_drive)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (sample_now) begin
            exp_t it;
            it = sb.pop_front();
            check(it.tag, rdata, it.exp);
        end
    end

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d, input logic sel);
        @(negedge clk);
        addr = a; wdata = d; cs = sel; wr = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        wr = 1'b0; cs = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic cpu_read(input logic [1:0] a, input logic [7:0] exp,
                            input logic sel, input string tag);
        exp_t it;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        addr = a; cs = sel; rd = 1'b1;
        repeat (5) @(posedge clk);
        #1 sample_now = 1'b1;
        @(negedge clk);
        #1 sample_now = 1'b0;
        rd = 1'b0; cs = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        repeat (2) @(posedge clk);

        // R3 reset state
        #1;
        check("R3 pa_out", pa_out, 8'h00);
        check("R3 pc_out", pc_out, 8'h00);
        check("R3 drives", pa_drive | pb_drive | pc_drive, 8'h00);
        cpu_read(2'd3, 8'h9B, 1'b1, "R3 R5 control reset");
        #1 check("R10 idle rdata", rdata, 8'h00);

        // R4 all outputs, R1 writes
        cpu_write(2'd3, 8'h80, 1'b1);
        #1 check("R4 all drive", pa_drive & pb_drive & pc_drive, 8'hFF);
        cpu_write(2'd0, 8'h5A, 1'b1);
        cpu_write(2'd1, 8'hC3, 1'b1);
        cpu_write(2'd2, 8'h96, 1'b1);
        #1;
        check("R1 pa_out", pa_out, 8'h5A);
        check("R1 pb_out", pb_out, 8'hC3);
        check("R1 pc_out", pc_out, 8'h96);
        cpu_read(2'd0, 8'h5A, 1'b1, "R8 R1 read A output reg");
        cpu_read(2'd2, 8'h96, 1'b1, "R8 read C output reg");

        // R2 chip select low
        cpu_write(2'd0, 8'hFF, 1'b0);
        #1 check("R2 pa_out unchanged", pa_out, 8'h5A);
        cpu_write(2'd3, 8'h9B, 1'b0);
        #1 check("R2 drives unchanged", pa_drive, 8'hFF);
        cpu_read(2'd0, 8'h00, 1'b0, "R2 read without cs");

        // R6 bit set/reset
        cpu_write(2'd3, 8'h01, 1'b1);
        #1 check("R6 set bit0", pc_out, 8'h97);
        cpu_write(2'd3, 8'h0E, 1'b1);
        #1 check("R6 clear bit7", pc_out, 8'h17);
        cpu_read(2'd3, 8'h80, 1'b1, "R6 control word unchanged");

        // R7 mode load clears
        cpu_write(2'd3, 8'h80, 1'b1);
        #1;
        check("R7 pa_out cleared", pa_out, 8'h00);
        check("R7 pb_out cleared", pb_out, 8'h00);
        check("R7 pc_out cleared", pc_out, 8'h00);

        // R4/R8 mixed directions: upper C and B input
        pb_in = 8'h3C; pc_in = 8'hA5;
        cpu_write(2'd3, 8'h8A, 1'b1);
        #1;
        check("R4 pa_drive", pa_drive, 8'hFF);
        check("R4 pb_drive", pb_drive, 8'h00);
        check("R4 pc_drive nibbles", pc_drive, 8'h0F);
        cpu_write(2'd2, 8'h66, 1'b1);
        cpu_write(2'd1, 8'h11, 1'b1);
        cpu_write(2'd0, 8'h42, 1'b1);
        #1 check("R1 pb_out reg while input", pb_out, 8'h11);
        cpu_read(2'd1, 8'h3C, 1'b1, "R8 read B pins");
        cpu_read(2'd2, 8'hA6, 1'b1, "R8 read C mixed nibbles");
        cpu_read(2'd0, 8'h42, 1'b1, "R8 read A output reg");
        cpu_read(2'd3, 8'h8A, 1'b1, "R5 readback");

        // R5 readback of other mode bits
        cpu_write(2'd3, 8'hF5, 1'b1);
        #1 check("R4 A input drive", pa_drive, 8'h00);
        cpu_read(2'd3, 8'hF5, 1'b1, "R5 readback high bits");

        // R9 held strobe
        cpu_write(2'd3, 8'h80, 1'b1);
        @(negedge clk);
        addr = 2'd0; wdata = 8'h21; cs = 1'b1; wr = 1'b1;
        repeat (8) @(posedge clk);
        @(negedge clk) wdata = 8'h99;
        repeat (8) @(posedge clk);
        #1 check("R9 single update", pa_out, 8'h21);
        @(negedge clk) wr = 1'b0; cs = 1'b0;
        repeat (4) @(posedge clk);
        #1 check("R10 idle rdata end", rdata, 8'h00);

        finish_run();
    end
endmodule